// File: doc/BRIEF.md
# RDS Group Status and Interrupt Controller

This block takes the per-group report of an RDS block decoder and turns it into host-visible status. Each report arrives as a one-cycle strobe together with a group-valid flag, the decoder's synchronization flag and a bit-error count for each of the four blocks of the group. From these the block produces a ready status bit held for a guaranteed minimum time, a synchronization status bit, four 2-bit error-level fields and an active-low interrupt pulse on a general-purpose pin.

Two reporting modes exist. In standard mode (the reset default) only valid groups count, and the synchronization bit and error levels read as zero. In verbose mode a group counts whenever the decoder is synchronized, and the synchronization bit and error levels are visible. Hold times derive from the clock-frequency parameter, so a bench can shrink them.

A three-state machine drives the ready bit and the pin. `ST_IDLE` is the rest state: ready low, pin high. A qualifying group moves any state to `ST_PULSE` and reloads both counters. `ST_PULSE` holds ready high and drives the pin low when the pin is set up for interrupts. It moves to `ST_HOLD` when the pulse counter runs out. `ST_HOLD` keeps ready high with the pin high. It returns to `ST_IDLE` when the hold counter runs out.

Top module: `rds_status_irq`

## Requirements
- R1: After reset, `rdy_o` is 0, `gpo_n_o` is 1, `sync_o` is 0, `blk_lvl_o` is 0 and the block is in standard mode behaviour.
- R2: With `verbose_i` = 0, a group strobe qualifies only when `grp_valid_i` = 1. A strobe with `grp_valid_i` = 0 changes neither `rdy_o` nor `gpo_n_o`.
- R3: With `verbose_i` = 0, `sync_o` and all of `blk_lvl_o` read 0.
- R4: With `verbose_i` = 1, `sync_o` equals `dec_sync_i` as sampled at the previous clock edge.
- R5: With `verbose_i` = 1, a group strobe qualifies exactly when `dec_sync_i` = 1, whatever the value of `grp_valid_i`.
- R6: After a qualifying strobe is sampled, `rdy_o` is high for exactly HOLD_CYC cycles, starting the next cycle. HOLD_CYC is CLK_HZ/1e6 × HOLD_US, 40 ms by default, and must exceed PULSE_CYC.
- R7: When `irq_en_i` = 1 and `pin_sel_i` = 2'b01, `gpo_n_o` is low for exactly PULSE_CYC cycles after each qualifying strobe, starting the next cycle. PULSE_CYC is CLK_HZ/1e6 × PULSE_US, 5 ms by default.
- R8: When `irq_en_i` = 0 or `pin_sel_i` ≠ 2'b01, `gpo_n_o` stays high.
- R9: Each block's error count is encoded as 2'b00 for 0 errors, 2'b01 for 1–2, 2'b10 for 3–5 and 2'b11 for 6 or more. Block k (k = 0..3) takes count bits [4k+3:4k] and level bits [2k+1:2k].
- R10: Error levels are captured on every group strobe, valid or not. They keep their value between strobes even if `blk_err_i` changes.
- R11: A qualifying strobe that arrives while a hold or pulse is still running restarts both the ready and pulse counts from their full values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| verbose_i | input | 1 | Mode select: 0 standard, 1 verbose |
| irq_en_i | input | 1 | Interrupt enable |
| pin_sel_i | input | 2 | Pin function; 2'b01 selects the group interrupt |
| grp_stb_i | input | 1 | One-cycle strobe per received group |
| grp_valid_i | input | 1 | Group judged valid by the decoder |
| dec_sync_i | input | 1 | Decoder block synchronization flag |
| blk_err_i | input | 4*ERR_W | Bit-error counts of blocks 0..3, block 0 lowest |
| rdy_o | output | 1 | Ready status bit |
| sync_o | output | 1 | Synchronization status bit |
| blk_lvl_o | output | 8 | Four 2-bit error levels, block 0 lowest |
| gpo_n_o | output | 1 | Active-low interrupt pin |

## Verification
On every cycle the assertions check the state machine's reaction to a qualifying strobe, the order `ST_PULSE` then `ST_HOLD`, the bounds on the pulse counter, and that the error levels hold still between strobes. Exact hold and pulse lengths, the retrigger behaviour, the mode-dependent qualification and gating, and the quantization boundaries (counts 0, 1, 2, 3, 5, 6 and 15) can only be shown by the bench scenarios against its cycle model.

// File: rtl/rds_irq_pkg.sv
package rds_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } irq_state_e;

    localparam int NUM_BLK = 4;
    localparam int LVL_W   = 2;

    localparam logic [1:0] PIN_FN_IRQ = 2'b01;

endpackage

// File: rtl/rds_err_quant.sv
module rds_err_quant #(
    parameter int ERR_W = 4
) (
    input  logic [ERR_W-1:0] cnt_i,
    output logic [1:0]       lvl_o
);
    localparam logic [ERR_W-1:0] LIM_LO  = ERR_W'(2);
    localparam logic [ERR_W-1:0] LIM_MID = ERR_W'(5);

    always_comb begin
        if (cnt_i == '0)
            lvl_o = 2'b00;
        else if (cnt_i <= LIM_LO)
            lvl_o = 2'b01;
        else if (cnt_i <= LIM_MID)
            lvl_o = 2'b10;
        else
            lvl_o = 2'b11;
    end
endmodule

// File: rtl/rds_irq_fsm.sv
module rds_irq_fsm
    import rds_irq_pkg::*;
#(
    parameter int HOLD_CYC  = 40,
    parameter int PULSE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    input  logic pin_on_i,
    output logic rdy_o,
    output logic pin_n_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [HW-1:0] HOLD_LOAD  = HW'(HOLD_CYC - 1);
    localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYC - 1);

    irq_state_e      state_q, state_d;
    logic [HW-1:0]   hold_q;
    logic [PW-1:0]   pls_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (qual_i) state_d = ST_PULSE;
            ST_PULSE: if (qual_i) state_d = ST_PULSE;
                      else if (pls_q == '0) state_d = ST_HOLD;
            ST_HOLD:  if (qual_i) state_d = ST_PULSE;
                      else if (hold_q == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            pls_q  <= '0;
        end else if (qual_i) begin
            hold_q <= HOLD_LOAD;
            pls_q  <= PULSE_LOAD;
        end else begin
            if (state_q != ST_IDLE && hold_q != '0) hold_q <= hold_q - 1'b1;
            if (state_q == ST_PULSE && pls_q != '0) pls_q <= pls_q - 1'b1;
        end
    end

    always_comb begin
        rdy_o   = (state_q != ST_IDLE);
        pin_n_o = !((state_q == ST_PULSE) && pin_on_i);
    end

    // R11
    qual_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qual_i |=> (state_q == ST_PULSE && pls_q == PULSE_LOAD && hold_q == HOLD_LOAD));

    // R6
    pulse_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !qual_i) |=> (state_q != ST_IDLE));

    // R7
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pls_q <= PULSE_LOAD));

    // R2
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !qual_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/rds_status_irq.sv
module rds_status_irq
    import rds_irq_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int HOLD_US  = 40_000,
    parameter int PULSE_US = 5_000,
    parameter int ERR_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   verbose_i,
    input  logic                   irq_en_i,
    input  logic [1:0]             pin_sel_i,
    input  logic                   grp_stb_i,
    input  logic                   grp_valid_i,
    input  logic                   dec_sync_i,
    input  logic [4*ERR_W-1:0]     blk_err_i,
    output logic                   rdy_o,
    output logic                   sync_o,
    output logic [7:0]             blk_lvl_o,
    output logic                   gpo_n_o
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int HOLD_CYC   = CYC_PER_US * HOLD_US;
    localparam int PULSE_CYC  = CYC_PER_US * PULSE_US;
    localparam int LVLS_W     = NUM_BLK * LVL_W;

    logic              qual;
    logic              pin_on;
    logic              sync_q;
    logic [LVLS_W-1:0] lvl_d, lvl_q;

    assign qual   = grp_stb_i && (verbose_i ? dec_sync_i : grp_valid_i);
    assign pin_on = irq_en_i && (pin_sel_i == PIN_FN_IRQ);

    for (genvar k = 0; k < NUM_BLK; k++) begin : g_quant
        rds_err_quant #(.ERR_W(ERR_W)) u_quant (
            .cnt_i (blk_err_i[k*ERR_W +: ERR_W]),
            .lvl_o (lvl_d[k*LVL_W +: LVL_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            lvl_q  <= '0;
        end else begin
            sync_q <= dec_sync_i;
            if (grp_stb_i) lvl_q <= lvl_d;
        end
    end

    rds_irq_fsm #(
        .HOLD_CYC  (HOLD_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual_i   (qual),
        .pin_on_i (pin_on),
        .rdy_o    (rdy_o),
        .pin_n_o  (gpo_n_o)
    );

    always_comb begin
        sync_o    = verbose_i ? sync_q : 1'b0;
        blk_lvl_o = verbose_i ? lvl_q  : '0;
    end

    initial begin
        if (HOLD_CYC <= PULSE_CYC || PULSE_CYC < 1)
            $error("hold time must exceed pulse time");
    end

    // R10
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_stb_i |=> $stable(lvl_q));

    // R8
    pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_on |-> gpo_n_o);
endmodule

// File: tb/rds_status_irq_tb.sv
module rds_status_irq_tb;
    localparam int HOLD_CYC  = 40;
    localparam int PULSE_CYC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        verbose = 1'b0, irq_en = 1'b0, stb = 1'b0, valid = 1'b0, dsync = 1'b0;
    logic [1:0]  pin_sel = 2'b00;
    logic [15:0] berr = '0;
    logic        rdy, sync_s, gpo_n;
    logic [7:0]  lvl;

    int checks = 0, errors = 0;
    string tag = "R1";
    bit run_chk = 1'b0;

    int   m_hold = 0, m_pls = 0;
    logic m_sync = 1'b0;
    logic [7:0] m_lvl = '0;

    always #5 clk = ~clk;

    rds_status_irq #(
        .CLK_HZ(1_000_000), .HOLD_US(HOLD_CYC), .PULSE_US(PULSE_CYC), .ERR_W(4)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .verbose_i(verbose), .irq_en_i(irq_en),
        .pin_sel_i(pin_sel), .grp_stb_i(stb), .grp_valid_i(valid),
        .dec_sync_i(dsync), .blk_err_i(berr), .rdy_o(rdy), .sync_o(sync_s),
        .blk_lvl_o(lvl), .gpo_n_o(gpo_n)
    );

    function automatic logic [1:0] quant(input int c);
        if (c == 0) return 2'b00;
        if (c <= 2) return 2'b01;
        if (c <= 5) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [7:0] quant_all(input logic [15:0] e);
        logic [7:0] r;
        for (int k = 0; k < 4; k++) r[2*k +: 2] = quant(int'(e[4*k +: 4]));
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold <= 0; m_pls <= 0; m_sync <= 1'b0; m_lvl <= '0;
        end else begin
            m_sync <= dsync;
            if (stb) m_lvl <= quant_all(berr);
            if (stb && (verbose ? dsync : valid)) begin
                m_hold <= HOLD_CYC; m_pls <= PULSE_CYC;
            end else begin
                if (m_hold > 0) m_hold <= m_hold - 1;
                if (m_pls > 0)  m_pls  <= m_pls - 1;
            end
        end
    end

    task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_chk) begin
            check("ready", {7'd0, rdy}, {7'd0, m_hold > 0});
            check("pin", {7'd0, gpo_n},
                  {7'd0, !(m_pls > 0 && irq_en && pin_sel == 2'b01)});
            check("sync", {7'd0, sync_s}, {7'd0, verbose ? m_sync : 1'b0});
            check("levels", lvl, verbose ? m_lvl : 8'h00);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic grp(input logic v, input logic s, input logic [15:0] e);
        @(posedge clk); #1;
        stb = 1'b1; valid = v; dsync = s; berr = e;
        @(posedge clk); #1;
        stb = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        check("reset ready", {7'd0, rdy}, 8'd0);
        check("reset pin", {7'd0, gpo_n}, 8'd1);
        check("reset sync", {7'd0, sync_s}, 8'd0);
        check("reset levels", lvl, 8'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run_chk = 1'b1;

        // R2: invalid group ignored, valid group sets ready and pulses
        tag = "R2"; irq_en = 1'b1; pin_sel = 2'b01;
        grp(1'b0, 1'b1, 16'h3333); idle(50);
        grp(1'b1, 1'b1, 16'h3333); idle(50);

        // R3: standard mode hides sync and levels
        tag = "R3";
        grp(1'b1, 1'b1, 16'hF621); idle(10);

        // R9: quantization boundaries in verbose mode
        tag = "R9"; verbose = 1'b1;
        grp(1'b1, 1'b1, 16'h3210); idle(3);
        grp(1'b1, 1'b1, 16'h6543); idle(3);
        grp(1'b1, 1'b1, 16'hF760); idle(3);
        grp(1'b1, 1'b1, 16'h0000); idle(50);

        // R5: verbose qualification follows sync, not valid
        tag = "R5";
        grp(1'b1, 1'b0, 16'h1111); idle(50);
        grp(1'b0, 1'b1, 16'h2222); idle(50);

        // R11: retrigger mid-hold and mid-pulse
        tag = "R11";
        grp(1'b1, 1'b1, 16'h0); idle(30);
        grp(1'b1, 1'b1, 16'h0); idle(2);
        grp(1'b1, 1'b1, 16'h0); idle(50);

        // R8: pin gated by enable and function select
        tag = "R8";
        irq_en = 1'b0; grp(1'b1, 1'b1, 16'h0); idle(10);
        irq_en = 1'b1; pin_sel = 2'b10; grp(1'b1, 1'b1, 16'h0); idle(10);
        pin_sel = 2'b11; grp(1'b1, 1'b1, 16'h0); idle(50);
        pin_sel = 2'b01;

        // R10: levels hold between strobes, captured on invalid strobes too
        tag = "R10";
        grp(1'b0, 1'b1, 16'h6F31); #1 berr = 16'h0000; idle(10);
        grp(1'b0, 1'b0, 16'h0002); #1 berr = 16'hFFFF; idle(10);

        // R4: sync status tracks decoder sync
        tag = "R4";
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1 dsync = 1'($urandom % 2);
        end
        idle(50);

        // R6 R7: random mix of modes, gating and strobes
        tag = "R6 R7";
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            stb   = ($urandom % 16 == 0);
            valid = ($urandom % 4 != 0);
            berr  = 16'($urandom);
            if ($urandom % 40 == 0)  dsync = ~dsync;
            if ($urandom % 500 == 0) verbose = ~verbose;
            if ($urandom % 300 == 0) begin
                irq_en  = 1'($urandom % 4 != 0);
                pin_sel = ($urandom % 2 == 0) ? 2'b01 : 2'($urandom);
            end
        end
        stb = 1'b0;
        idle(60);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule